// File: doc/BRIEF.md
# Single-Command DMA Transfer Engine

This block carries out one DMA command that has already been loaded. It reads from a source address and writes to a destination address through a simple single-cycle memory port. Each side has its own access width and its own address-increment switch. A fixed address on one side models a peripheral FIFO register. Bytes pass through a staging register one bus word wide. Each unit of work, called a chunk, is as wide as the wider of the two accesses. The engine fills a chunk with reads and then drains it with writes.

Chunks are grouped into bursts, whose length is set by a programmed byte limit. When request pacing is on, every burst waits for the peripheral's request line. A live remaining-size value lets software work out how much is left. That value reads all-ones while the engine is idle and again once the last write lands. For this reason, the largest transfer accepted is one bus width short of the field's limit.

Top module: `dma_cmd_engine`

## Requirements
- R1: After reset and while idle, `active_size` is all ones, `done` is low, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: The read width is `gen_cfg[2:0]` and the write width is `gen_cfg[6:4]`, each given as log2 of the byte count. A value wider than the bus is treated as the bus width. A transfer of N bytes makes N/readbytes reads and N/writebytes writes, where N is a multiple of the larger width.
- R3: `gen_cfg[8]` set makes the read address advance by the read width after each read, and `gen_cfg[12]` does the same for the write address. When a bit is clear, that side's address stays fixed.
- R4: Byte i of the stream is taken from byte (i mod readbytes) of the current read access and lands at the destination in stream order. The result in memory matches a byte-by-byte copy under the increment rules of R3.
- R5: The burst limit in bytes is `port_cfg[11:4]` plus one. A burst ends at the first chunk boundary where the bytes written in that burst reach the limit.
- R6: With `port_cfg[1]` set, no read starts at the beginning of a transfer or after a burst boundary until `dreq` is seen high. With the bit clear, `dreq` is ignored.
- R7: If either start address is not a multiple of the bus width in bytes, the burst limit is reduced by one bus width, with a floor of one byte.
- R8: `len_m1` is the byte count minus one. From the cycle after start, `active_size` shows the remaining bytes minus one. It changes only when a write is made, and then drops by the write width.
- R9: A `len_m1` above 2^24 minus one minus the bus width in bytes is clamped to that value.
- R10: `done` pulses high for exactly one cycle when the remaining count reaches zero, and `active_size` reads all ones from that cycle on.
- R11: A `start` pulse while a transfer is in progress is ignored.
- R12: `mem_tid` carries `port_cfg[27:24]` during reads and `port_cfg[19:16]` during writes.
- R13: The byte at address a travels on lane (a mod bus bytes) of `mem_rdata` and `mem_wdata`, and a write asserts `mem_wbe` on exactly the lanes it covers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the loaded command (ignored while busy) |
| gen_cfg | input | 32 | Widths and increment switches |
| port_cfg | input | 32 | Burst limit, request enable, thread IDs |
| rd_base | input | AW | Source start address |
| wr_base | input | AW | Destination start address |
| len_m1 | input | 24 | Byte count minus one |
| dreq | input | 1 | Peripheral request for the next burst |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 8*BUS_BYTES | Write data on byte lanes |
| mem_wbe | output | BUS_BYTES | Write byte enables |
| mem_rdata | input | 8*BUS_BYTES | Read data, one cycle after `mem_rd` |
| mem_tid | output | 4 | Thread ID of the current access |
| done | output | 1 | One-cycle completion pulse |
| active_size | output | 24 | Remaining bytes minus one; all ones when idle |

## Verification
The hardest state to reach from the ports is an engine that is busy but idle on the bus. The clamp of R9 and the ignored restart of R11 can only be seen there, since a maximum-length transfer would otherwise run for millions of cycles. The stimulus enables request pacing and holds `dreq` low, which parks the engine at its first burst gate. There `active_size` can be read and a second `start` applied before a reset clears it. Burst grouping is measured the same way. The bench gives one `dreq` pulse each time the bus has been quiet for several cycles, and compares the number of pulses with the burst count that the limit and the alignment rule predict.

// File: rtl/dma_cmd_engine.sv
module dma_cmd_engine #(
  parameter int AW        = 16,
  parameter int BUS_BYTES = 4,
  parameter int SZW       = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            gen_cfg,
  input  logic [31:0]            port_cfg,
  input  logic [AW-1:0]          rd_base,
  input  logic [AW-1:0]          wr_base,
  input  logic [SZW-1:0]         len_m1,
  input  logic                   dreq,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [AW-1:0]          mem_addr,
  output logic [8*BUS_BYTES-1:0] mem_wdata,
  output logic [BUS_BYTES-1:0]   mem_wbe,
  input  logic [8*BUS_BYTES-1:0] mem_rdata,
  output logic [3:0]             mem_tid,
  output logic                   done,
  output logic [SZW-1:0]         active_size
);
  localparam int LB  = $clog2(BUS_BYTES);
  localparam int CW  = LB + 2;
  localparam int BCW = LB + 10;
  localparam int DW  = 8 * BUS_BYTES;
  localparam logic [SZW:0] LEN_CAP = (SZW+1)'((64'd1 << SZW) - 64'd1 - 64'(BUS_BYTES));

  typedef enum logic [2:0] {ST_IDLE, ST_GATE, ST_RD, ST_CAP, ST_WR} st_t;

  st_t            st;
  logic [2:0]     rlog, wlog;
  logic           inc_r, inc_w, gate_en;
  logic [8:0]     blim;
  logic [3:0]     rtid, wtid;
  logic [AW-1:0]  raddr, waddr;
  logic [SZW:0]   rem;
  logic [CW-1:0]  fill, wpos;
  logic [BCW-1:0] bcnt;
  logic [7:0]     stg [BUS_BYTES];
  logic           done_q;
  logic           waiting;

  function automatic logic [2:0] clamp_log(input logic [2:0] f);
    return (f > 3'(LB)) ? 3'(LB) : f;
  endfunction

  logic [CW-1:0] rbytes, wbytes, chunk;
  assign rbytes = CW'(1) << rlog;
  assign wbytes = CW'(1) << wlog;
  assign chunk  = (rlog > wlog) ? rbytes : wbytes;

  logic [LB-1:0] rlane, wlane, wpos_lb;
  assign rlane   = raddr[LB-1:0];
  assign wlane   = waddr[LB-1:0];
  assign wpos_lb = wpos[LB-1:0];

  logic [DW-1:0] rd_rot;
  assign rd_rot = DW'({mem_rdata, mem_rdata} >> (8 * rlane));

  logic [8:0]   bl_raw, bl_eff;
  logic         misal;
  logic [SZW:0] len_c;
  assign bl_raw = {1'b0, port_cfg[11:4]} + 9'd1;
  assign misal  = (rd_base[LB-1:0] != '0) || (wr_base[LB-1:0] != '0);
  assign bl_eff = !misal ? bl_raw :
                  (bl_raw > 9'(BUS_BYTES)) ? bl_raw - 9'(BUS_BYTES) : 9'd1;
  assign len_c  = ({1'b0, len_m1} > LEN_CAP) ? LEN_CAP : {1'b0, len_m1};

  logic cfg_unused;
  assign cfg_unused = ^{gen_cfg[31:13], gen_cfg[11:9], gen_cfg[7], gen_cfg[3],
                        port_cfg[31:28], port_cfg[23:20], port_cfg[15:12],
                        port_cfg[3:2], port_cfg[0]};

  logic chunk_full, chunk_drained, last_write, burst_met;
  assign chunk_full    = (fill + rbytes) >= chunk;
  assign chunk_drained = (wpos + wbytes) >= chunk;
  assign last_write    = rem <= (SZW+1)'(wbytes);
  assign burst_met     = (bcnt + BCW'(wbytes)) >= BCW'(blim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rlog    <= '0;
      wlog    <= '0;
      inc_r   <= 1'b0;
      inc_w   <= 1'b0;
      gate_en <= 1'b0;
      blim    <= 9'd1;
      rtid    <= '0;
      wtid    <= '0;
      raddr   <= '0;
      waddr   <= '0;
      rem     <= '0;
      fill    <= '0;
      wpos    <= '0;
      bcnt    <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < BUS_BYTES; k++) stg[k] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          rlog    <= clamp_log(gen_cfg[2:0]);
          wlog    <= clamp_log(gen_cfg[6:4]);
          inc_r   <= gen_cfg[8];
          inc_w   <= gen_cfg[12];
          gate_en <= port_cfg[1];
          blim    <= bl_eff;
          rtid    <= port_cfg[27:24];
          wtid    <= port_cfg[19:16];
          raddr   <= rd_base;
          waddr   <= wr_base;
          rem     <= len_c + 1'b1;
          fill    <= '0;
          wpos    <= '0;
          bcnt    <= '0;
          st      <= ST_GATE;
        end
        ST_GATE: if (!gate_en || dreq) begin
          bcnt <= '0;
          st   <= ST_RD;
        end
        ST_RD: st <= ST_CAP;
        ST_CAP: begin
          for (int k = 0; k < BUS_BYTES; k++)
            if (CW'(k) < rbytes) stg[LB'(fill) + LB'(k)] <= rd_rot[8*k +: 8];
          fill <= fill + rbytes;
          if (inc_r) raddr <= raddr + AW'(rbytes);
          if (chunk_full) begin
            wpos <= '0;
            st   <= ST_WR;
          end else begin
            st <= ST_RD;
          end
        end
        ST_WR: begin
          wpos <= wpos + wbytes;
          bcnt <= bcnt + BCW'(wbytes);
          rem  <= last_write ? '0 : rem - (SZW+1)'(wbytes);
          if (inc_w) waddr <= waddr + AW'(wbytes);
          if (chunk_drained) begin
            fill <= '0;
            if (last_write) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else if (burst_met) begin
              st <= ST_GATE;
            end else begin
              st <= ST_RD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_wdata = '0;
    mem_wbe   = '0;
    if (st == ST_WR) begin
      for (int ln = 0; ln < BUS_BYTES; ln++) begin
        if (CW'(LB'(ln) - wlane) < wbytes) begin
          mem_wdata[8*ln +: 8] = stg[wpos_lb + (LB'(ln) - wlane)];
          mem_wbe[ln]          = 1'b1;
        end
      end
    end
  end

  assign mem_rd      = (st == ST_RD);
  assign mem_wr      = (st == ST_WR);
  assign mem_addr    = (st == ST_WR) ? waddr : raddr;
  assign mem_tid     = (st == ST_WR) ? wtid : (st == ST_RD) ? rtid : 4'd0;
  assign done        = done_q;
  assign active_size = SZW'(rem - 1'b1);
  assign waiting     = (st == ST_GATE) && gate_en;
endmodule

// File: rtl/dma_cmd_engine_chk.sv
module dma_cmd_engine_chk #(
  parameter int BUS_BYTES = 4,
  parameter int SZW       = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 dreq,
  input logic                 waiting,
  input logic                 mem_rd,
  input logic                 mem_wr,
  input logic [BUS_BYTES-1:0] mem_wbe,
  input logic                 done,
  input logic [SZW-1:0]       active_size
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active_size == '1) |-> (!mem_rd && !mem_wr)); // R1
  AST_DONE_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active_size == '1)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_SIZE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ((active_size < $past(active_size)) || done)); // R8
  AST_SIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr && !start) |=> $stable(active_size)); // R8
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !dreq) |=> (!mem_rd && !mem_wr)); // R6
  AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wbe != '0)); // R13
endmodule

bind dma_cmd_engine dma_cmd_engine_chk #(.BUS_BYTES(BUS_BYTES), .SZW(SZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dreq(dreq), .waiting(waiting),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wbe(mem_wbe), .done(done),
  .active_size(active_size)
);

// File: tb/sim_dma_cmd_engine.sv
`timescale 1ns/1ps
module sim_dma_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] gen_cfg = '0, port_cfg = '0;
  logic [15:0] rd_base = '0, wr_base = '0;
  logic [23:0] len_m1 = '0;
  logic        dreq = 1'b0;
  logic        mem_rd, mem_wr, done;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_wbe, mem_tid;
  logic [23:0] active_size;

  always #2.5 clk = ~clk;

  dma_cmd_engine #(.AW(16), .BUS_BYTES(4), .SZW(24)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .gen_cfg(gen_cfg), .port_cfg(port_cfg),
    .rd_base(rd_base), .wr_base(wr_base), .len_m1(len_m1), .dreq(dreq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wbe(mem_wbe), .mem_rdata(mem_rdata), .mem_tid(mem_tid), .done(done),
    .active_size(active_size));

  function automatic logic [7:0] img(int j);
    return 8'(j * 37 + 11);
  endfunction

  logic [7:0] mem [1024];
  logic       reload = 1'b0;
  always @(posedge clk) begin
    if (reload) begin
      for (int j = 0; j < 1024; j++) mem[j] <= img(j);
    end else if (mem_wr) begin
      for (int b = 0; b < 4; b++)
        if (mem_wbe[b]) mem[{mem_addr[9:2], 2'(b)}] <= mem_wdata[8*b +: 8];
    end
    if (mem_rd)
      for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] <= mem[{mem_addr[9:2], 2'(b)}];
  end

  int n_rd = 0, n_wr = 0, tid_bad = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (mem_rd) begin n_rd++; if (mem_tid != 4'hA) tid_bad++; end
    if (mem_wr) begin n_wr++; if (mem_tid != 4'h5) tid_bad++; end
    if (done) done_cnt++;
  end

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  rw;
    logic [2:0]  ww;
    logic        ir;
    logic        iw;
    logic [7:0]  bf;
    logic        den;
    logic [15:0] ra;
    logic [15:0] wa;
    logic [15:0] len;
    logic [7:0]  erd;
    logic [7:0]  ewr;
    logic [7:0]  ebu;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 3'd2, 1'b1, 1'b1, 8'd15, 1'b0, 16'h100, 16'h200, 16'd32, 8'd8,  8'd8,  8'd0},
    '{3'd0, 3'd2, 1'b1, 1'b1, 8'd15, 1'b0, 16'h121, 16'h240, 16'd12, 8'd12, 8'd3,  8'd0},
    '{3'd2, 3'd1, 1'b1, 1'b1, 8'd15, 1'b0, 16'h140, 16'h262, 16'd16, 8'd4,  8'd8,  8'd0},
    '{3'd1, 3'd2, 1'b0, 1'b1, 8'd15, 1'b0, 16'h302, 16'h280, 16'd8,  8'd4,  8'd2,  8'd0},
    '{3'd2, 3'd0, 1'b1, 1'b0, 8'd15, 1'b0, 16'h160, 16'h3F1, 16'd8,  8'd2,  8'd8,  8'd0},
    '{3'd2, 3'd2, 1'b1, 1'b1, 8'd7,  1'b1, 16'h180, 16'h2A0, 16'd32, 8'd8,  8'd8,  8'd4},
    '{3'd1, 3'd1, 1'b1, 1'b1, 8'd11, 1'b1, 16'h1A2, 16'h2C2, 16'd24, 8'd12, 8'd12, 8'd3},
    '{3'd2, 3'd2, 1'b1, 1'b1, 8'd0,  1'b1, 16'h1C0, 16'h2E0, 16'd12, 8'd3,  8'd3,  8'd3},
    '{3'd7, 3'd2, 1'b1, 1'b1, 8'd15, 1'b0, 16'h1D0, 16'h310, 16'd8,  8'd2,  8'd2,  8'd0}
  };

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; dreq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input vec_t v, input logic [23:0] lm1);
    gen_cfg  = 32'(v.rw) | (32'(v.ww) << 4) | (32'(v.ir) << 8) | (32'(v.iw) << 12);
    port_cfg = (32'hC << 28) | (32'hA << 24) | (32'h5 << 16) | (32'(v.bf) << 4) | (32'(v.den) << 1);
    rd_base  = v.ra;
    wr_base  = v.wa;
    len_m1   = lm1;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VEC[idx];
    int r0, w0, t0, d0, quiet, pulses, cyc, bad, rb, wb, s, d;
    logic [7:0] e [1024];
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
    r0 = n_rd; w0 = n_wr; t0 = tid_bad; d0 = done_cnt;
    load(v, 24'(v.len) - 24'd1);
    quiet = 0; pulses = 0; cyc = 0;
    while (done_cnt == d0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      dreq = 1'b0;
      if (mem_rd || mem_wr) quiet = 0; else quiet++;
      if (v.den && quiet >= 4 && done_cnt == d0) begin
        dreq = 1'b1; pulses++; quiet = 0;
      end
    end
    dreq = 1'b0;
    repeat (2) @(negedge clk);
    rb = 1 << ((v.rw > 3'd2) ? 2 : int'(v.rw));
    wb = 1 << ((v.ww > 3'd2) ? 2 : int'(v.ww));
    for (int j = 0; j < 1024; j++) e[j] = img(j);
    for (int i = 0; i < int'(v.len); i++) begin
      s = v.ir ? int'(v.ra) + i : int'(v.ra) + (i % rb);
      d = v.iw ? int'(v.wa) + i : int'(v.wa) + (i % wb);
      e[d] = img(s);
    end
    bad = 0;
    for (int j = 0; j < 1024; j++) if (mem[j] !== e[j]) bad++;
    chk(bad == 0, "R4/R3/R13", $sformatf("v%0d image bytes wrong", idx), bad, 0);
    chk(n_rd - r0 == int'(v.erd), "R2", $sformatf("v%0d read count", idx), n_rd - r0, v.erd);
    chk(n_wr - w0 == int'(v.ewr), "R2", $sformatf("v%0d write count", idx), n_wr - w0, v.ewr);
    chk(done_cnt - d0 == 1, "R10", $sformatf("v%0d done pulses", idx), done_cnt - d0, 1);
    chk(active_size == 24'hFFFFFF, "R10", $sformatf("v%0d size after end", idx), active_size, 24'hFFFFFF);
    chk(tid_bad == t0, "R12", $sformatf("v%0d thread id errors", idx), tid_bad - t0, 0);
    if (v.den)
      chk(pulses == int'(v.ebu), "R5/R6/R7", $sformatf("v%0d bursts", idx), pulses, v.ebu);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int r0, d0, cyc;
    do_reset();
    chk(active_size == 24'hFFFFFF, "R1", "reset size", active_size, 24'hFFFFFF);
    chk(!mem_rd && !mem_wr, "R1", "reset strobes", {mem_rd, mem_wr}, 0);
    chk(!done, "R1", "reset done", done, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R6 / R8 / R11: parked at the gate
    do_reset();
    r0 = n_rd;
    load(VEC[5], 24'd31);
    repeat (10) @(negedge clk);
    chk(n_rd == r0, "R6", "read before dreq", n_rd - r0, 0);
    chk(active_size == 24'd31, "R8", "size at gate", active_size, 31);
    load(VEC[0], 24'd5);
    @(negedge clk);
    chk(active_size == 24'd31, "R11", "restart ignored", active_size, 31);

    // R9: cap on length
    do_reset();
    load(VEC[5], 24'hFFFFFF);
    @(negedge clk);
    chk(active_size == 24'hFFFFFB, "R9", "capped size", active_size, 24'hFFFFFB);

    // R8: countdown on write
    do_reset();
    d0 = done_cnt;
    load(VEC[0], 24'd31);
    chk(active_size == 24'd31, "R8", "size after start", active_size, 31);
    cyc = 0;
    while (!mem_wr && cyc < 50) begin @(negedge clk); cyc++; end
    @(negedge clk);
    chk(active_size == 24'd27, "R8", "size after first write", active_size, 27);
    cyc = 0;
    while (done_cnt == d0 && cyc < 500) begin @(negedge clk); cyc++; end
    chk(done_cnt - d0 == 1, "R10", "countdown run done", done_cnt - d0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule